// File: doc/BRIEF.md
# Two-Road Timed Traffic Signal Sequencer

This block controls the signals at a crossing of two one-way roads, one running north and one running east. It is a Moore machine: the lamp vector depends only on the current phase. Each phase's lamp pattern, dwell length and successor phases come from a constant lookup held in a package. A successor is picked by the two car sensors, and only at the moment a phase's dwell runs out.

A prescaler divides the system clock into a base tick. The nominal tick is 10 ms, and the divisor is the parameter `CLKS_PER_TICK`. A down-counter measures each phase's dwell in ticks. When the count ends, the synchronised sensor pair is sampled, the successor is looked up, and the counter is reloaded with the successor's dwell. It is reloaded even when the successor is the same phase. The sensor inputs pass through a two-flop synchroniser, and the lamp vector is registered.

Top module: `junction_signal_ctrl`

## Requirements
- R1: While `rst_n` is low and after it rises, the machine is in the north-go phase and `lamp_out` is 6'b100001.
- R2: Bits [5:3] of `lamp_out` are east red, yellow and green, and bits [2:0] are north red, yellow and green. The patterns are: north-go 100001, north-amber 100010, east-go 001100, east-amber 010100.
- R3: A tick occurs every `CLKS_PER_TICK` clocks. A green phase lasts exactly `GREEN_TICKS` ticks and an amber phase exactly `AMBER_TICKS` ticks, so `lamp_out` changes exactly dwell×`CLKS_PER_TICK` clocks after the phase began (counted from reset release for the first phase).
- R4: In north-go, the sensor value `car_sense` = {north, east} selects the next phase: 0 gives north-go, 1 gives north-amber, 2 gives north-go, 3 gives north-amber.
- R5: North-amber is always followed by east-go, whatever the sensors read.
- R6: In east-go, sensor values 0 and 1 give east-go, and values 2 and 3 give east-amber.
- R7: East-amber is always followed by north-go, whatever the sensors read.
- R8: When a phase selects itself, its dwell restarts in full before the sensors are sampled again.
- R9: Only the sensor value present (after two clocks of synchronisation) when a dwell expires matters. Values that appear and go away earlier in the dwell have no effect.
- R10: `lamp_out` never shows green on both roads.
- R11: `lamp_out` changes only at a dwell expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| car_sense | input | 2 | Bit 1: cars waiting north; bit 0: cars waiting east (asynchronous) |
| lamp_out | output | 6 | Registered lamp vector, east R/Y/G in [5:3], north R/Y/G in [2:0] |

## Verification
The bench sweeps all sixteen pairs of phase and sensor value. Phases are reached by running the full four-phase cycle with both sensors set. In every visit it checks the lamps one clock before the expected expiry and again one clock after it, so a dwell that is off by one tick or one clock is caught. A counter that is not reloaded on a self-transition would show up as a short second visit to a green phase. A sampler that looks at the sensors continuously, instead of at expiry, would follow the early sensor pulses that the bench injects and then withdraws. A table entry with the wrong index, or a mirrored sensor bit, would produce the wrong successor in one of the sixteen visits.

// File: rtl/sigctl_pkg.sv
`timescale 1ns/1ps
// Package: phase encoding and the constant phase table (lamps, successor,
// dwell class). Assumes sensor word {north, east} and 6-bit lamp vector.
package sigctl_pkg;
    localparam int LAMP_W = 6;
    localparam int SENS_W = 2;

    typedef enum logic [1:0] {
        PH_N_GO    = 2'd0,
        PH_N_AMBER = 2'd1,
        PH_E_GO    = 2'd2,
        PH_E_AMBER = 2'd3
    } phase_e;

    // Lamp pattern of a phase: [5:3] east R/Y/G, [2:0] north R/Y/G.
    function automatic logic [LAMP_W-1:0] phase_lamps(input phase_e p);
        case (p)
            PH_N_GO:    phase_lamps = 6'b100001;
            PH_N_AMBER: phase_lamps = 6'b100010;
            PH_E_GO:    phase_lamps = 6'b001100;
            default:    phase_lamps = 6'b010100;
        endcase
    endfunction

    // Successor phase indexed by current phase and sensor word.
    function automatic phase_e phase_next(input phase_e p, input logic [SENS_W-1:0] cars);
        case (p)
            PH_N_GO:    phase_next = cars[0] ? PH_N_AMBER : PH_N_GO;
            PH_N_AMBER: phase_next = PH_E_GO;
            PH_E_GO:    phase_next = cars[1] ? PH_E_AMBER : PH_E_GO;
            default:    phase_next = PH_N_GO;
        endcase
    endfunction

    // Dwell class of a phase: 1 for green phases, 0 for amber.
    function automatic logic phase_is_green(input phase_e p);
        phase_is_green = (p == PH_N_GO) || (p == PH_E_GO);
    endfunction
endpackage

// File: rtl/sigctl_tick.sv
`timescale 1ns/1ps
// Module: base-tick prescaler. Emits a one-clock pulse every CLKS_PER_TICK
// clocks; the first pulse is in the CLKS_PER_TICK-th clock after reset.
// Assumes CLKS_PER_TICK >= 1.
module sigctl_tick #(
    parameter int CLKS_PER_TICK = 2_000_000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (CLKS_PER_TICK > 1) ? $clog2(CLKS_PER_TICK) : 1;
    localparam logic [CW-1:0] LAST = CW'(CLKS_PER_TICK - 1);

    logic [CW-1:0] cnt_q;

    // Free-running modulo counter that wraps at LAST.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= '0;
        else if (cnt_q == LAST)  cnt_q <= '0;
        else                     cnt_q <= cnt_q + 1'b1;
    end

    assign tick = (cnt_q == LAST);

    generate
        if (CLKS_PER_TICK > 1) begin : g_spacing
            // R3
            tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate
endmodule

// File: rtl/sigctl_sync.sv
`timescale 1ns/1ps
// Module: multi-flop synchroniser for the asynchronous car sensors.
// Assumes STAGES >= 2; output resets to zero.
module sigctl_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    // Shift the raw sample through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], d};
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/sigctl_dwell.sv
`timescale 1ns/1ps
// Module: dwell down-counter in ticks. Flags expiry on the final tick of a
// dwell and reloads with load_val on that tick. Assumes all loads are >= 1.
module sigctl_dwell #(
    parameter int DW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic [DW-1:0] init_val,
    input  logic [DW-1:0] load_val,
    output logic          expire
);
    logic [DW-1:0] remain_q;

    // Count ticks down; reload on the last one.
    always_ff @(posedge clk) begin
        if (!rst_n)      remain_q <= init_val;
        else if (tick)   remain_q <= (remain_q == DW'(1)) ? load_val : remain_q - 1'b1;
    end

    assign expire = tick && (remain_q == DW'(1));

    // R3
    remain_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        remain_q != '0);
    // R8
    reload_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> remain_q == $past(load_val));
    // R3
    hold_between_ticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(remain_q));
endmodule

// File: rtl/junction_signal_ctrl.sv
`timescale 1ns/1ps
// Module: top of the two-road signal sequencer. Holds the current phase,
// looks up lamps, successor and dwell from sigctl_pkg, and advances only
// on dwell expiry. Assumes GREEN_TICKS, AMBER_TICKS, CLKS_PER_TICK >= 1.
module junction_signal_ctrl #(
    parameter int CLKS_PER_TICK = 2_000_000,
    parameter int GREEN_TICKS   = 3000,
    parameter int AMBER_TICKS   = 500,
    parameter int SYNC_STAGES   = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] car_sense,
    output logic [5:0] lamp_out
);
    import sigctl_pkg::*;

    localparam int MAXD = (GREEN_TICKS > AMBER_TICKS) ? GREEN_TICKS : AMBER_TICKS;
    localparam int DW   = $clog2(MAXD + 1);
    localparam logic [DW-1:0] GREEN_LEN = DW'(GREEN_TICKS);
    localparam logic [DW-1:0] AMBER_LEN = DW'(AMBER_TICKS);

    logic              tick;
    logic              expire;
    logic [SENS_W-1:0] cars_s;
    phase_e            phase_q;
    phase_e            phase_d;
    logic [DW-1:0]     load_val;
    logic [LAMP_W-1:0] lamps_q;

    sigctl_tick #(.CLKS_PER_TICK(CLKS_PER_TICK)) u_tick (
        .clk(clk), .rst_n(rst_n), .tick(tick)
    );

    sigctl_sync #(.WIDTH(SENS_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(car_sense), .q(cars_s)
    );

    sigctl_dwell #(.DW(DW)) u_dwell (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .init_val(GREEN_LEN), .load_val(load_val), .expire(expire)
    );

    // Table lookup: successor of the current phase and its dwell length.
    always_comb begin
        phase_d  = phase_next(phase_q, cars_s);
        load_val = phase_is_green(phase_d) ? GREEN_LEN : AMBER_LEN;
    end

    // Phase and lamp registers; move only when the dwell expires.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_N_GO;
            lamps_q <= phase_lamps(PH_N_GO);
        end else if (expire) begin
            phase_q <= phase_d;
            lamps_q <= phase_lamps(phase_d);
        end
    end

    assign lamp_out = lamps_q;

    // R1
    reset_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (lamp_out == 6'b100001));
    // R2
    one_lamp_per_road_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(lamp_out[5:3]) == 1) && ($countones(lamp_out[2:0]) == 1));
    // R10
    no_dual_green_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(lamp_out[3] && lamp_out[0]));
    // R11
    lamp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !expire |=> $stable(lamp_out));
    // R5
    north_amber_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lamp_out == 6'b100010 && expire) |=> (lamp_out == 6'b001100));
    // R7
    east_amber_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lamp_out == 6'b010100 && expire) |=> (lamp_out == 6'b100001));
    // R4
    north_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_N_GO && expire && !cars_s[0]) |=> (lamp_out == 6'b100001));
    // R6
    east_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_E_GO && expire && !cars_s[1]) |=> (lamp_out == 6'b001100));
endmodule

// File: tb/junction_signal_ctrl_tb.sv
`timescale 1ns/1ps
module junction_signal_ctrl_tb;
    localparam int NCLK = 3;
    localparam int GT   = 6;
    localparam int AT   = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] car_sense = 2'b00;
    logic [5:0] lamp_out;

    int checks = 0;
    int failures = 0;
    int dual_green = 0;
    int m_state = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    junction_signal_ctrl #(.CLKS_PER_TICK(NCLK), .GREEN_TICKS(GT), .AMBER_TICKS(AT)) u_dut (
        .clk(clk), .rst_n(rst_n), .car_sense(car_sense), .lamp_out(lamp_out)
    );

    function automatic logic [5:0] exp_lamp(input int s);
        case (s)
            0: return 6'b100001;
            1: return 6'b100010;
            2: return 6'b001100;
            default: return 6'b010100;
        endcase
    endfunction

    function automatic int exp_next(input int s, input int v);
        case (s)
            0: return (v == 1 || v == 3) ? 1 : 0;
            1: return 2;
            2: return (v >= 2) ? 3 : 2;
            default: return 0;
        endcase
    endfunction

    function automatic int dwell_clks(input int s);
        return ((s == 0 || s == 2) ? GT : AT) * NCLK;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [5:0] act, input logic [5:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic step_edge();
        @(posedge clk);
        @(negedge clk);
    endtask

    // One visit to the current phase: drive 'early' for early_n clocks, then v;
    // check lamps one clock before and right after the expected expiry.
    task automatic visit(input logic [1:0] v, input logic [1:0] early, input int early_n, input string tag);
        int d;
        int nxt;
        d = dwell_clks(m_state);
        nxt = exp_next(m_state, int'(v));
        car_sense = early;
        for (int i = 0; i < early_n; i++) step_edge();
        car_sense = v;
        for (int i = 0; i < d - 1 - early_n; i++) step_edge();
        chk(lamp_out == exp_lamp(m_state), {tag, " R3 R11 before-expiry"}, lamp_out, exp_lamp(m_state));
        step_edge();
        chk(lamp_out == exp_lamp(nxt), {tag, " R2 R3 after-expiry"}, lamp_out, exp_lamp(nxt));
        m_state = nxt;
    endtask

    task automatic go_to(input int s);
        while (m_state != s) visit(2'b11, 2'b11, 0, "R3 nav");
    endtask

    // R10: watch for both roads green on every cycle out of reset.
    always @(negedge clk) begin
        if (rst_n && lamp_out[3] && lamp_out[0]) dual_green++;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        string tags[4];
        tags[0] = "R4";
        tags[1] = "R5";
        tags[2] = "R6";
        tags[3] = "R7";
        car_sense = 2'b11;
        repeat (4) @(negedge clk);
        chk(lamp_out == 6'b100001, "R1 during reset", lamp_out, 6'b100001);
        rst_n = 1'b1;
        chk(lamp_out == 6'b100001, "R1 after release", lamp_out, 6'b100001);
        m_state = 0;

        // Exhaustive sweep of phase x sensor value.
        for (int s = 0; s < 4; s++) begin
            for (int v = 0; v < 4; v++) begin
                go_to(s);
                visit(2'(v), 2'(v), 0, tags[s]);
            end
        end

        // R8: repeated self-loops each wait a full dwell.
        go_to(0);
        visit(2'b00, 2'b00, 0, "R8");
        visit(2'b10, 2'b10, 0, "R8");
        visit(2'b01, 2'b01, 0, "R8");
        go_to(2);
        visit(2'b01, 2'b01, 0, "R8");
        visit(2'b00, 2'b00, 0, "R8");
        visit(2'b10, 2'b10, 0, "R8");

        // R9: early sensor pulses that vanish before expiry are ignored.
        go_to(0);
        visit(2'b00, 2'b11, 12, "R9");
        visit(2'b00, 2'b01, 12, "R9");
        visit(2'b01, 2'b00, 12, "R9");
        go_to(2);
        visit(2'b00, 2'b10, 12, "R9");
        visit(2'b01, 2'b11, 12, "R9");

        chk(dual_green == 0, "R10 dual green count", 6'(dual_green), 6'd0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule